// File: doc/BRIEF.md
# Dynamically Tapped Delay Line

This block is a single-bit serial delay line, replicated across a number of independent lanes, whose read point is chosen at run time. Each lane is built from a chain of cells. Every cell holds up to sixteen storage stages that advance together on a clock edge while the shift enable is high. A tap address picks one stage of the chain, and that stage drives the tap output through combinational logic. A new address therefore changes the delay at once, with no clock edge needed.

The tap address has two fields. The low four bits choose a stage inside a cell: a value of N reads stage N+1, which is N+1 enabled shifts old. The bits above them choose the cell. With the default sixteen-stage cells, address A gives a delay of (A[high] * 16) + A[3:0] + 1 enabled shifts. A separate chain output always carries the final stage of the final cell, whatever the address. It can feed the serial input of another copy of the block to build a longer line. Stored contents start at zero and there is no reset. A cell field that names a cell beyond the last one reads the last cell. A stage field beyond a shorter cell's depth reads that cell's final stage.

Top module: `dyn_tap_delay`

## Requirements
- R1: On each rising clock edge with shift_en high, the first stage of every lane captures that lane's ser_in bit, so tap address 0 shows the bit ser_in held one enabled edge earlier.
- R2: While shift_en is low, no stage changes: with the address held, tap_out and chain_out keep their values across clock edges.
- R3: Within cell 0 (upper address field zero), a stage field of N presents on tap_out the ser_in bit from N+1 enabled shifts ago, for N from 0 to 15.
- R4: The upper address field selects the cell: address with cell field C and stage field N gives a delay of C*CELL_DEPTH + N + 1 enabled shifts.
- R5: A change of tap_addr changes tap_out without any clock edge; the output reflects the newly addressed stage as soon as the logic settles.
- R6: chain_out always carries the final stage of the last cell, a delay of NUM_CELLS*CELL_DEPTH enabled shifts, independent of tap_addr.
- R7: All stages start at zero, so before NUM_CELLS*CELL_DEPTH enabled shifts have happened chain_out is 0, and every tap reading a stage not yet written is 0.
- R8: Lanes are independent: bit L of tap_out and chain_out depends only on bit L of ser_in, with all lanes sharing one address and one enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| shift_en | input | 1 | Clock enable; stages advance only while high |
| ser_in | input | LANES | Serial data, one bit per lane |
| tap_addr | input | ADDR_W (6 by default) | Bits [3:0] stage in cell, upper bits cell index |
| tap_out | output | LANES | Combinational read of the addressed stage, per lane |
| chain_out | output | LANES | Final stage of the last cell, per lane, for chaining |

## Verification
The bench looks hardest at the ends of the address range. An off-by-one in the stage decode would give a delay of N or N+2 instead of N+1, which address 0 and address 15 expose at once. A wrong cell decode or a swapped address field would give delays off by multiples of sixteen, which random full-range addresses show on every cycle. It also holds the enable low while it sweeps every address between clock edges: a registered read would lag by a cycle, and a shift that ignored the enable would drift the data. The first sixty-four shifts and the two lanes fed different streams catch stages that do not start at zero and lanes that share or cross data.

// File: rtl/dtap_pkg.sv
package dtap_pkg;

   // Width of the stage field inside one cell
   localparam int TAP_W          = 4;
   // Largest number of stages one cell may hold
   localparam int MAX_CELL_DEPTH = 16;

   // Bits needed to name a cell; a single cell still gets one (ignored) bit
   function automatic int sel_width(input int n_cells);
      return (n_cells > 1) ? $clog2(n_cells) : 1;
   endfunction

   // True when n is a power of two (cell field decodes with no spare codes)
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/dtap_cell.sv
module dtap_cell #(
   parameter int DEPTH = 16
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic                    din,
   input  logic [dtap_pkg::TAP_W-1:0] tap,
   output logic                    tap_q,
   output logic                    last_q
);
   import dtap_pkg::*;

   logic [DEPTH-1:0] stg = '0;

   // Shift structure: a single stage cannot be sliced, so pick the variant
   generate
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (en) stg <= din;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (en) stg <= {stg[DEPTH-2:0], din};
         end
      end
   endgenerate

   assign last_q = stg[DEPTH-1];

   // Read mux: a full-depth cell needs no clamp, a shorter one clamps
   generate
      if (DEPTH == MAX_CELL_DEPTH) begin : g_full
         assign tap_q = stg[tap];
      end else begin : g_short
         logic [TAP_W-1:0] idx;
         always_comb begin
            if (32'(tap) >= DEPTH) idx = TAP_W'(DEPTH - 1);
            else                   idx = tap;
         end
         assign tap_q = stg[idx];
      end
   endgenerate

endmodule

// File: rtl/dtap_lane.sv
module dtap_lane #(
   parameter int NUM_CELLS  = 4,
   parameter int CELL_DEPTH = 16,
   parameter int SEL_W      = 2
) (
   input  logic                       clk,
   input  logic                       en,
   input  logic                       din,
   input  logic [SEL_W-1:0]           cell_sel,
   input  logic [dtap_pkg::TAP_W-1:0] tap,
   output logic                       tap_q,
   output logic                       chain_q
);
   import dtap_pkg::*;

   logic [NUM_CELLS:0]   link;
   logic [NUM_CELLS-1:0] cell_tap;

   assign link[0] = din;

   for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
      dtap_cell #(.DEPTH(CELL_DEPTH)) u_cell (
         .clk    (clk),
         .en     (en),
         .din    (link[c]),
         .tap    (tap),
         .tap_q  (cell_tap[c]),
         .last_q (link[c+1])
      );
   end

   assign chain_q = link[NUM_CELLS];

   // Cell select: three variants depending on how the cell field decodes
   generate
      if (NUM_CELLS == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^cell_sel;
         assign tap_q      = cell_tap[0];
      end else if (is_pow2(NUM_CELLS)) begin : g_pow2
         assign tap_q = cell_tap[cell_sel];
      end else begin : g_clamp
         logic [SEL_W-1:0] sel_c;
         always_comb begin
            if (32'(cell_sel) >= NUM_CELLS) sel_c = SEL_W'(NUM_CELLS - 1);
            else                            sel_c = cell_sel;
         end
         assign tap_q = cell_tap[sel_c];
      end
   endgenerate

endmodule

// File: rtl/dyn_tap_delay.sv
module dyn_tap_delay #(
   parameter  int LANES      = 2,
   parameter  int NUM_CELLS  = 4,
   parameter  int CELL_DEPTH = 16,
   localparam int SEL_W      = dtap_pkg::sel_width(NUM_CELLS),
   localparam int ADDR_W     = SEL_W + dtap_pkg::TAP_W,
   localparam int TOTAL      = NUM_CELLS * CELL_DEPTH
) (
   input  logic              clk,
   input  logic              shift_en,
   input  logic [LANES-1:0]  ser_in,
   input  logic [ADDR_W-1:0] tap_addr,
   output logic [LANES-1:0]  tap_out,
   output logic [LANES-1:0]  chain_out
);
   import dtap_pkg::*;

   // Elaboration-time parameter checks
   if (LANES < 1) begin : g_bad_lanes
      $error("dyn_tap_delay: LANES must be at least 1");
   end
   if (NUM_CELLS < 1) begin : g_bad_cells
      $error("dyn_tap_delay: NUM_CELLS must be at least 1");
   end
   if (CELL_DEPTH < 1 || CELL_DEPTH > MAX_CELL_DEPTH) begin : g_bad_depth
      $error("dyn_tap_delay: CELL_DEPTH must lie in 1..16");
   end

   logic [SEL_W-1:0] cell_sel;
   logic [TAP_W-1:0] stage_sel;

   assign stage_sel = tap_addr[TAP_W-1:0];
   assign cell_sel  = tap_addr[ADDR_W-1:TAP_W];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      dtap_lane #(
         .NUM_CELLS  (NUM_CELLS),
         .CELL_DEPTH (CELL_DEPTH),
         .SEL_W      (SEL_W)
      ) u_lane (
         .clk      (clk),
         .en       (shift_en),
         .din      (ser_in[l]),
         .cell_sel (cell_sel),
         .tap      (stage_sel),
         .tap_q    (tap_out[l]),
         .chain_q  (chain_out[l])
      );
   end

endmodule

// File: rtl/dtap_chk.sv
module dtap_chk #(
   parameter int LANES  = 2,
   parameter int ADDR_W = 6,
   parameter int TOTAL  = 64
) (
   input logic              clk,
   input logic              shift_en,
   input logic [LANES-1:0]  ser_in,
   input logic [ADDR_W-1:0] tap_addr,
   input logic [LANES-1:0]  tap_out,
   input logic [LANES-1:0]  chain_out
);
   // Becomes true after the first edge so $past never reaches before time zero
   logic        primed  = 1'b0;
   // Enabled shifts seen so far, saturating at the line length
   int unsigned n_shift = 0;

   always_ff @(posedge clk) begin
      primed <= 1'b1;
      if (shift_en && n_shift < TOTAL) n_shift <= n_shift + 1;
   end

   AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!primed)
      (shift_en && tap_addr == '0) |=> ((tap_addr == '0) -> (tap_out == $past(ser_in)))); // R1

   AST_HOLD_CHAIN: assert property (@(posedge clk) disable iff (!primed)
      !shift_en |=> $stable(chain_out)); // R2

   AST_HOLD_TAP: assert property (@(posedge clk) disable iff (!primed)
      !shift_en |=> ($stable(tap_addr) -> $stable(tap_out))); // R2

   AST_LAST_TAP_IS_CHAIN: assert property (@(posedge clk) disable iff (!primed)
      (&tap_addr) |-> (tap_out == chain_out)); // R6

   AST_POWERUP_ZERO: assert property (@(posedge clk) disable iff (!primed)
      (n_shift < TOTAL) |-> (chain_out == '0)); // R7

endmodule

bind dyn_tap_delay dtap_chk #(
   .LANES  (LANES),
   .ADDR_W (ADDR_W),
   .TOTAL  (TOTAL)
) u_chk (
   .clk       (clk),
   .shift_en  (shift_en),
   .ser_in    (ser_in),
   .tap_addr  (tap_addr),
   .tap_out   (tap_out),
   .chain_out (chain_out)
);

// File: tb/dyn_tap_delay_tb.sv
module dyn_tap_delay_tb;
   localparam int LANES      = 2;
   localparam int NUM_CELLS  = 4;
   localparam int CELL_DEPTH = 16;
   localparam int ADDR_W     = 6;
   localparam int TOTAL      = NUM_CELLS * CELL_DEPTH;

   typedef struct {
      logic [LANES-1:0] exp_tap;
      logic [LANES-1:0] exp_chain;
      string            tag;
   } item_t;

   logic              clk = 1'b0;
   logic              shift_en = 1'b0;
   logic [LANES-1:0]  ser_in = '0;
   logic [ADDR_W-1:0] tap_addr = '0;
   logic [LANES-1:0]  tap_out;
   logic [LANES-1:0]  chain_out;

   int    n_checks = 0;
   int    n_bad    = 0;
   bit    finished = 1'b0;
   item_t sb_q[$];

   // Model of the line per the requirements: bit 0 is the newest shifted bit
   logic [TOTAL-1:0] hist [LANES];
   logic [15:0]      lfsr = 16'hACE1;

   always #5 clk = ~clk;

   dyn_tap_delay #(
      .LANES      (LANES),
      .NUM_CELLS  (NUM_CELLS),
      .CELL_DEPTH (CELL_DEPTH)
   ) u_dut (
      .clk       (clk),
      .shift_en  (shift_en),
      .ser_in    (ser_in),
      .tap_addr  (tap_addr),
      .tap_out   (tap_out),
      .chain_out (chain_out)
   );

   function automatic int delay_of(input logic [ADDR_W-1:0] a);
      return int'(a[ADDR_W-1:4]) * CELL_DEPTH + int'(a[3:0]) + 1;
   endfunction

   function automatic logic [LANES-1:0] model_tap(input logic [ADDR_W-1:0] a);
      logic [LANES-1:0] r;
      for (int l = 0; l < LANES; l++) r[l] = hist[l][delay_of(a) - 1];
      return r;
   endfunction

   function automatic logic [LANES-1:0] model_chain();
      logic [LANES-1:0] r;
      for (int l = 0; l < LANES; l++) r[l] = hist[l][TOTAL-1];
      return r;
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic check(input string tag, input string what,
                        input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%b exp=%b addr=%0d", tag, what, act, exp, tap_addr);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the expected outputs
   task automatic drive(input logic en, input logic [LANES-1:0] din,
                        input logic [ADDR_W-1:0] a, input string tag);
      item_t it;
      @(negedge clk);
      shift_en = en;
      ser_in   = din;
      tap_addr = a;
      @(posedge clk);
      if (en)
         for (int l = 0; l < LANES; l++) hist[l] = {hist[l][TOTAL-2:0], din[l]};
      it.exp_tap   = model_tap(a);
      it.exp_chain = model_chain();
      it.tag       = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: compares the settled outputs after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, "tap_out", tap_out, it.exp_tap);
            check("R6", "chain_out", chain_out, it.exp_chain);
         end
      end
   end

   // Watchdog
   initial begin
      #2000000;
      if (!finished) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < LANES; l++) hist[l] = '0;

      // R7: contents are zero before any shift
      #1;
      check("R7", "tap_out at start", tap_out, '0);
      check("R7", "chain_out at start", chain_out, '0);
      for (int a = 0; a < (1 << ADDR_W); a += 7) begin
         tap_addr = ADDR_W'(a);
         #1;
         check("R7", "tap_out unwritten stage", tap_out, '0);
      end

      // R1: address 0, one-cycle delay; both lanes get the same stream
      for (int i = 0; i < 70; i++) begin
         step_lfsr();
         drive(1'b1, {LANES{lfsr[0]}}, '0, "R1");
      end

      // R3: stage field sweeps cell 0, including 0 and 15
      for (int i = 0; i < 64; i++) begin
         step_lfsr();
         drive(1'b1, {lfsr[3], lfsr[0]}, ADDR_W'(i % 16), "R3");
      end

      // R2: enable toggles with a fixed address; held cycles keep outputs
      for (int i = 0; i < 48; i++) begin
         step_lfsr();
         drive(lfsr[5], {lfsr[7], lfsr[2]}, ADDR_W'(5), lfsr[5] ? "R3" : "R2");
      end
      for (int i = 0; i < 6; i++) drive(1'b0, 2'b11, ADDR_W'(63), "R2");

      // R4: random addresses across every cell
      for (int i = 0; i < 120; i++) begin
         step_lfsr();
         drive(1'b1, {lfsr[9], lfsr[1]}, ADDR_W'(lfsr[15:10]), "R4");
      end

      // R8: lanes fed opposite and unrelated streams
      for (int i = 0; i < 80; i++) begin
         step_lfsr();
         drive(1'b1, (i < 40) ? {~lfsr[4], lfsr[4]} : {1'b1, lfsr[6]},
               ADDR_W'(lfsr[11:6]), "R8");
      end

      // R5: enable low, address changes between edges take effect at once
      @(negedge clk);
      shift_en = 1'b0;
      #1;
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         tap_addr = ADDR_W'(a);
         #1;
         check("R5", "tap_out after address change", tap_out, model_tap(ADDR_W'(a)));
      end

      repeat (3) @(posedge clk);
      #3;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule